// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Sequencer

This block is the transmit-side controller of a source-synchronous clock lane. It starts in the low-power stop state. On request it walks the lane through a fixed low-power handshake into a continuously toggling high-speed clock. When the request is withdrawn it walks the lane back to stop. Each phase length is a cycle count on the timing clock `clk_i`, taken from a configuration input when that phase begins. A count of zero is treated as one cycle.

The block coordinates with the data-lane sequencers in two ways. `clk_ready_o` tells them that the clock has run long enough for a data lane to begin its own high-speed entry. The `data_hs_i` bits report which data lanes are still in high-speed mode. A stop request is held off until every one of those bits reads low, so the clock keeps running after the last data lane has returned to low power.

Top module: `clk_lane_seq`

## Requirements
- R1: After reset, and while `hs_req_i` stays low in stop, `line_o` is 0 (LP-11) and `clk_ready_o` is 0.
- R2: When `hs_req_i` is high in stop, the lane drives LP-11 for the current cycle. It then drives 1 (LP-01) for the lpx count and then 2 (LP-00) for the prepare count.
- R3: After LP-00, the lane drives 3 (HS-0) for the zero count and then 4 (HS clock toggling).
- R4: `clk_ready_o` rises after the clock has toggled for the pre count. It stays high while the lane is running.
- R5: `clk_ready_o` is high only while `line_o` is 4, and never during the pre or post phases.
- R6: When `hs_req_i` drops while no data lane is in HS, the clock toggles for one more cycle plus the post count, with `clk_ready_o` low during the post count. The lane then drives HS-0 for the trail count and LP-11 for at least the lpx count. A request raised during exit is not honoured until that LP-11 period ends.
- R7: While any `data_hs_i` bit is high, a low `hs_req_i` does not end the running state. Exit starts on the cycle after all bits read low.
- R8: A configured count of zero gives a one-cycle phase. A count of N (N>0) gives exactly N cycles.
- R9: Once entry has started, withdrawing `hs_req_i` does not abort it. The lane completes entry, runs for one cycle with `clk_ready_o` high, and then exits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_req_i | input | 1 | Request for high-speed clocking |
| data_hs_i | input | NUM_LANES | Per data lane: lane is in HS mode |
| cfg_lpx_i | input | CNT_W | Low-power state length, cycles |
| cfg_prep_i | input | CNT_W | LP-00 prepare length, cycles |
| cfg_zero_i | input | CNT_W | HS-0 before clocking, cycles |
| cfg_pre_i | input | CNT_W | Clocking before ready, cycles |
| cfg_post_i | input | CNT_W | Clocking after data lanes idle, cycles |
| cfg_trail_i | input | CNT_W | HS-0 after last clock, cycles |
| line_o | output | 3 | Line state: 0 LP-11, 1 LP-01, 2 LP-00, 3 HS-0, 4 HS clock |
| clk_ready_o | output | 1 | Pre interval complete; data lanes may enter HS |

## Verification
The bench compares the exact per-cycle line code sequence for several interval sets, including all-zero counts. A design with an off-by-one in its timer, or one that fails to promote zero counts, would stretch or shorten phases and shift the whole stream. A stop request is withdrawn while a data lane is still active; a design that ignored `data_hs_i` would cut the clock early. A new request is raised during exit, and another request is withdrawn mid-entry. A design that aborted or re-entered too soon would skip the trailing LP-11 period, or would never reach the ready state.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;
  typedef enum logic [2:0] {
    LINE_LP11  = 3'd0,
    LINE_LP01  = 3'd1,
    LINE_LP00  = 3'd2,
    LINE_HS0   = 3'd3,
    LINE_HSCLK = 3'd4
  } line_e;

  typedef enum logic [3:0] {
    ST_STOP, ST_LP01, ST_LP00, ST_HS0, ST_PRE,
    ST_RUN, ST_POST, ST_TRAIL, ST_EXIT
  } state_e;
endpackage

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // zero length promoted to one cycle: both load a remaining count of 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
  import clk_lane_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hs_req_i,
  input  logic [NUM_LANES-1:0] data_hs_i,
  input  logic                 tmr_done_i,
  input  logic [CNT_W-1:0]     cfg_lpx_i,
  input  logic [CNT_W-1:0]     cfg_prep_i,
  input  logic [CNT_W-1:0]     cfg_zero_i,
  input  logic [CNT_W-1:0]     cfg_pre_i,
  input  logic [CNT_W-1:0]     cfg_post_i,
  input  logic [CNT_W-1:0]     cfg_trail_i,
  output logic                 tmr_load_o,
  output logic [CNT_W-1:0]     tmr_len_o,
  output state_e               state_o
);
  state_e st_q, st_d;
  logic   any_hs;

  assign any_hs = |data_hs_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_STOP:  if (hs_req_i)              st_d = ST_LP01;
      ST_LP01:  if (tmr_done_i)            st_d = ST_LP00;
      ST_LP00:  if (tmr_done_i)            st_d = ST_HS0;
      ST_HS0:   if (tmr_done_i)            st_d = ST_PRE;
      ST_PRE:   if (tmr_done_i)            st_d = ST_RUN;
      ST_RUN:   if (!hs_req_i && !any_hs)  st_d = ST_POST;
      ST_POST:  if (tmr_done_i)            st_d = ST_TRAIL;
      ST_TRAIL: if (tmr_done_i)            st_d = ST_EXIT;
      ST_EXIT:  if (tmr_done_i)            st_d = ST_STOP;
      default:                             st_d = ST_STOP;
    endcase
  end

  // interval for the phase being entered, sampled on the transition
  always_comb begin
    unique case (st_d)
      ST_LP01, ST_EXIT: tmr_len_o = cfg_lpx_i;
      ST_LP00:          tmr_len_o = cfg_prep_i;
      ST_HS0:           tmr_len_o = cfg_zero_i;
      ST_PRE:           tmr_len_o = cfg_pre_i;
      ST_POST:          tmr_len_o = cfg_post_i;
      ST_TRAIL:         tmr_len_o = cfg_trail_i;
      default:          tmr_len_o = '0;
    endcase
  end

  assign tmr_load_o = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_STOP;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/clk_lane_enc.sv
module clk_lane_enc
  import clk_lane_pkg::*;
(
  input  state_e     state_i,
  output logic [2:0] line_o,
  output logic       ready_o
);
  line_e ln;

  always_comb begin
    unique case (state_i)
      ST_LP01:                  ln = LINE_LP01;
      ST_LP00:                  ln = LINE_LP00;
      ST_HS0, ST_TRAIL:         ln = LINE_HS0;
      ST_PRE, ST_RUN, ST_POST:  ln = LINE_HSCLK;
      default:                  ln = LINE_LP11;
    endcase
  end

  assign line_o  = ln;
  assign ready_o = (state_i == ST_RUN);
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hs_req_i,
  input  logic [NUM_LANES-1:0] data_hs_i,
  input  logic [CNT_W-1:0]     cfg_lpx_i,
  input  logic [CNT_W-1:0]     cfg_prep_i,
  input  logic [CNT_W-1:0]     cfg_zero_i,
  input  logic [CNT_W-1:0]     cfg_pre_i,
  input  logic [CNT_W-1:0]     cfg_post_i,
  input  logic [CNT_W-1:0]     cfg_trail_i,
  output logic [2:0]           line_o,
  output logic                 clk_ready_o
);
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_len;
  state_e           state;

  clk_lane_fsm #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .hs_req_i, .data_hs_i,
    .tmr_done_i (tmr_done),
    .cfg_lpx_i, .cfg_prep_i, .cfg_zero_i, .cfg_pre_i, .cfg_post_i, .cfg_trail_i,
    .tmr_load_o (tmr_load),
    .tmr_len_o  (tmr_len),
    .state_o    (state)
  );

  clk_lane_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  clk_lane_enc u_enc (
    .state_i (state),
    .line_o  (line_o),
    .ready_o (clk_ready_o)
  );
endmodule

// File: rtl/clk_lane_seq_chk.sv
module clk_lane_seq_chk
  import clk_lane_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 hs_req_i,
  input logic [NUM_LANES-1:0] data_hs_i,
  input logic [2:0]           line_o,
  input logic                 clk_ready_o
);
  AST_LP01_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == LINE_LP01 && $past(line_o) != LINE_LP01) |-> $past(line_o) == LINE_LP11); // R2

  AST_LP00_FROM_LP01: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == LINE_LP00 && $past(line_o) != LINE_LP00) |-> $past(line_o) == LINE_LP01); // R2

  AST_CLK_FROM_HS0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == LINE_HSCLK && $past(line_o) != LINE_HSCLK) |-> $past(line_o) == LINE_HS0); // R3

  AST_READY_ON_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ready_o |-> line_o == LINE_HSCLK); // R5

  AST_READY_RISE_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_ready_o) |-> $past(line_o) == LINE_HSCLK); // R4

  AST_HOLD_WHILE_DATA_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_ready_o && |data_hs_i) |=> clk_ready_o); // R7

  AST_LP11_FROM_TRAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == LINE_LP11 && $past(line_o) != LINE_LP11) |-> $past(line_o) == LINE_HS0); // R6
endmodule

bind clk_lane_seq clk_lane_seq_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i, .rst_ni, .hs_req_i, .data_hs_i, .line_o, .clk_ready_o
);

// File: tb/clk_lane_seq_test.sv
module clk_lane_seq_test;
  localparam int NL = 2;
  localparam int CW = 8;
  localparam bit [2:0] LP11 = 3'd0, LP01 = 3'd1, LP00 = 3'd2, HS0 = 3'd3, HSC = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req;
  logic [NL-1:0] dhs;
  logic [CW-1:0] c_lpx, c_prep, c_zero, c_pre, c_post, c_trail;
  logic [2:0]    line;
  logic          rdy;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit [2:0] q_line[$];
  bit       q_rdy[$];
  string    q_tag[$];

  clk_lane_seq #(.NUM_LANES(NL), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hs_req_i(req), .data_hs_i(dhs),
    .cfg_lpx_i(c_lpx), .cfg_prep_i(c_prep), .cfg_zero_i(c_zero),
    .cfg_pre_i(c_pre), .cfg_post_i(c_post), .cfg_trail_i(c_trail),
    .line_o(line), .clk_ready_o(rdy)
  );

  function automatic int eff(input logic [CW-1:0] v);
    return (v == '0) ? 1 : int'(v);
  endfunction

  task automatic push(input bit [2:0] l, input bit r, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      q_line.push_back(l);
      q_rdy.push_back(r);
      q_tag.push_back(tag);
    end
  endtask

  task automatic push_entry();
    push(LP01, 1'b0, eff(c_lpx),  "R2");
    push(LP00, 1'b0, eff(c_prep), "R2");
    push(HS0,  1'b0, eff(c_zero), "R3");
    push(HSC,  1'b0, eff(c_pre),  "R5");
  endtask

  task automatic push_exit(input string tag);
    push(HSC,  1'b0, eff(c_post),  tag);
    push(HS0,  1'b0, eff(c_trail), tag);
    push(LP11, 1'b0, eff(c_lpx),   tag);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q_line.size() != 0) @(negedge clk);
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input int d,
                         input int e, input int f);
    c_lpx = CW'(a); c_prep = CW'(b); c_zero = CW'(c);
    c_pre = CW'(d); c_post = CW'(e); c_trail = CW'(f);
  endtask

  // monitor: one expected item per cycle, compared mid-cycle
  always @(negedge clk) begin
    if (rst_n && !finished && q_line.size() != 0) begin
      bit [2:0] el;
      bit       er;
      string    t;
      el = q_line.pop_front();
      er = q_rdy.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (line !== el || rdy !== er) begin
        errors++;
        $display("FAIL %s: line=%0d ready=%0b expected line=%0d ready=%0b", t, line, rdy, el, er);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    req = 1'b0;
    dhs = '0;
    set_cfg(3, 2, 4, 5, 6, 3);
    #9;
    checks++;
    if (line !== LP11 || rdy !== 1'b0) begin
      errors++;
      $display("FAIL R1: line=%0d ready=%0b expected line=0 ready=0", line, rdy);
    end
    step();
    rst_n = 1'b1;

    // R1 idle
    step();
    push(LP11, 1'b0, 4, "R1");
    drain();

    // R2 R3 R4 entry with distinct counts
    step();
    req = 1'b1;
    push(LP11, 1'b0, 1, "R2");
    push_entry();
    push(HSC, 1'b1, 3, "R4");
    drain();

    // R6 stop, re-request raised during post
    step();
    req = 1'b0;
    push(HSC, 1'b1, 1, "R6");
    push_exit("R6");
    push(LP11, 1'b0, 1, "R6");
    push_entry();
    push(HSC, 1'b1, 2, "R4");
    step();
    step();
    req = 1'b1;
    drain();

    // R7 deferred stop while a data lane is in HS
    step();
    dhs = 2'b10;
    push(HSC, 1'b1, 1, "R7");
    drain();
    step();
    req = 1'b0;
    push(HSC, 1'b1, 6, "R7");
    drain();
    step();
    dhs = '0;
    push(HSC, 1'b1, 1, "R7");
    push_exit("R7");
    push(LP11, 1'b0, 3, "R7");
    drain();

    // R9 request withdrawn during entry
    step();
    req = 1'b1;
    push(LP11, 1'b0, 1, "R9");
    push_entry();
    push(HSC, 1'b1, 1, "R9");
    push_exit("R9");
    push(LP11, 1'b0, 2, "R9");
    step();
    req = 1'b0;
    drain();

    // R8 all counts zero
    step();
    set_cfg(0, 0, 0, 0, 0, 0);
    req = 1'b1;
    push(LP11, 1'b0, 1, "R8");
    push_entry();
    push(HSC, 1'b1, 2, "R8");
    drain();
    step();
    req = 1'b0;
    push(HSC, 1'b1, 1, "R8");
    push_exit("R8");
    push(LP11, 1'b0, 2, "R8");
    drain();

    // R8 another pattern with single-cycle and long phases
    step();
    set_cfg(2, 1, 9, 1, 4, 5);
    req = 1'b1;
    push(LP11, 1'b0, 1, "R8");
    push_entry();
    push(HSC, 1'b1, 2, "R8");
    drain();
    step();
    req = 1'b0;
    push(HSC, 1'b1, 1, "R8");
    push_exit("R8");
    push(LP11, 1'b0, 2, "R8");
    drain();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule